// File: doc/BRIEF.md
# Class-Selected Multifunction ALU

This block is a purely combinational integer ALU for a simple single-issue datapath. Two operands enter, and a small control word picks the operation. A two-bit class code selects which of four result sources reaches the output. The four sources are a path that places an upper immediate, a signed set-on-less-than path, a shared adder/subtractor, and a four-function bitwise unit. The set-on-less-than path reuses the adder's difference, so the adder must be put in subtract mode for that class.

The surrounding datapath picks the operands and extends immediates before they arrive here. A three-bit shift code is carried on the interface so the control word keeps its full width. Shifting itself is not implemented, and the shift code is consumed without effect. Besides the result, the block reports a zero flag and a signed-overflow flag. The control unit can use the zero flag for branch decisions and the overflow flag for trapping arithmetic.

Top module: `class_alu`

## Requirements
- R1: The class code picks the result source: 0 = upper-immediate placement, 1 = set-on-less-than, 2 = adder/subtractor, 3 = bitwise unit.
- R2: In class 0 the result holds operand B bits 15:0 in result bits 31:16, and result bits 15:0 are zero.
- R3: In class 1, with the subtract bit set, the result is 1 when A is less than B as signed 32-bit integers and 0 otherwise. This holds also when A minus B overflows.
- R4: In class 2 the result is A plus B modulo 2^32 when the subtract bit is 0, and A minus B modulo 2^32 when it is 1.
- R5: In class 3 the bitwise code picks the function: 0 = AND, 1 = OR, 2 = XOR, 3 = NOR.
- R6: The zero flag is high exactly when all 32 result bits are zero, in every class.
- R7: In class 2 the overflow flag is high exactly when the signed sum or difference does not fit in 32 bits. In classes 0, 1 and 3 it is low.
- R8: The shift code has no effect on the result, zero or overflow outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (already muxed/extended) |
| fn_class | input | 2 | Result source select |
| sub_en | input | 1 | 1 = adder subtracts B from A |
| bit_fn | input | 2 | Bitwise function select |
| shift_code | input | 3 | Shift control, carried but unused |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zero |
| overflow | output | 1 | Signed overflow of the adder in class 2 |

## Verification
The hardest case to reach from the ports is a set-on-less-than in which the difference overflows. There the sign of the raw difference gives the wrong answer, and only operands of opposite sign near the ends of the range produce it. Uniform random operands seldom land there. The stimulus therefore combines directed extreme pairs (most negative against small positives, most positive against negative values) with random operands whose top bits are forced apart. Random vectors also sweep every class with random shift codes, and each result is compared against a reference that performs the signed comparison and the overflow test in wider integer arithmetic.

// File: rtl/class_alu_pkg.sv
package class_alu_pkg;

    typedef enum logic [1:0] {
        CLS_UPPER = 2'd0,
        CLS_SLT   = 2'd1,
        CLS_ARITH = 2'd2,
        CLS_BITS  = 2'd3
    } fn_class_e;

    typedef enum logic [1:0] {
        BF_AND = 2'd0,
        BF_OR  = 2'd1,
        BF_XOR = 2'd2,
        BF_NOR = 2'd3
    } bit_fn_e;

endpackage

// File: rtl/cla_addsub.sv
module cla_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             less
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        less  = sum[WIDTH-1] ^ ovf;
        if (sub && (a == b)) begin
            AST_SUB_SELF_ZERO: assert (sum == '0 && !ovf && !less); // R4
        end
    end
endmodule

// File: rtl/cla_bitwise.sv
module cla_bitwise
    import class_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (bit_fn_e'(fn))
                BF_AND:  y[i] = a[i] & b[i];
                BF_OR:   y[i] = a[i] | b[i];
                BF_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~(a[i] | b[i]);
            endcase
        end
    end
endmodule

// File: rtl/cla_upper_imm.sv
module cla_upper_imm #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    localparam int IMM_W = WIDTH / 2;
    localparam int LOW_W = WIDTH - IMM_W;

    logic unused_b_high;
    assign unused_b_high = ^b[WIDTH-1:IMM_W];

    always_comb begin
        y = {b[IMM_W-1:0], {LOW_W{1'b0}}};
        AST_UPPER_LOW_CLEAR: assert (y[LOW_W-1:0] == '0); // R2
    end
endmodule

// File: rtl/class_alu.sv
module class_alu
    import class_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       fn_class,
    input  logic             sub_en,
    input  logic [1:0]       bit_fn,
    input  logic [2:0]       shift_code,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);
    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             zero;
        logic             ovf;
    } alu_out_t;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] bits_w;
    logic [WIDTH-1:0] upper_w;
    logic             ovf_w;
    logic             less_w;
    logic             unused_shift_code;
    alu_out_t         out_d;

    assign unused_shift_code = ^shift_code;

    cla_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .sub  (sub_en),
        .sum  (sum_w),
        .ovf  (ovf_w),
        .less (less_w)
    );

    cla_bitwise #(.WIDTH(WIDTH)) u_bits (
        .a  (op_a),
        .b  (op_b),
        .fn (bit_fn),
        .y  (bits_w)
    );

    cla_upper_imm #(.WIDTH(WIDTH)) u_upper (
        .b (op_b),
        .y (upper_w)
    );

    always_comb begin
        out_d = '0;
        unique case (fn_class_e'(fn_class))
            CLS_UPPER: out_d.value = upper_w;
            CLS_SLT:   out_d.value = {{(WIDTH-1){1'b0}}, less_w};
            CLS_ARITH: begin
                out_d.value = sum_w;
                out_d.ovf   = ovf_w;
            end
            default:   out_d.value = bits_w;
        endcase
        out_d.zero = (out_d.value == '0);
    end

    assign result   = out_d.value;
    assign zero     = out_d.zero;
    assign overflow = out_d.ovf;

    always_comb begin
        if (fn_class != CLS_ARITH) begin
            AST_NO_OVERFLOW: assert (!overflow); // R7
        end
        if (fn_class == CLS_SLT) begin
            AST_SLT_ONE_BIT: assert (result[WIDTH-1:1] == '0); // R3
        end
        if (fn_class == CLS_BITS && bit_fn == BF_XOR && op_a == op_b) begin
            AST_XOR_SELF_ZERO: assert (zero); // R6
        end
        if (fn_class == CLS_BITS && bit_fn == BF_NOR && op_a == '0) begin
            AST_NOR_NONZERO: assert (!zero || op_b == '1); // R5
        end
    end
endmodule

// File: tb/tb_class_alu.sv
module tb_class_alu;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  fn_class = '0, bit_fn = '0;
    logic        sub_en = 1'b0;
    logic [2:0]  shift_code = '0;
    logic [31:0] result;
    logic        zero, overflow;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    class_alu dut (
        .op_a(op_a), .op_b(op_b), .fn_class(fn_class), .sub_en(sub_en),
        .bit_fn(bit_fn), .shift_code(shift_code),
        .result(result), .zero(zero), .overflow(overflow)
    );

    function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b,
                                            logic [1:0] c, logic s, logic [1:0] f);
        case (c)
            2'd0: return {b[15:0], 16'h0000};
            2'd1: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            2'd2: return s ? a - b : a + b;
            default: case (f)
                2'd0: return a & b;
                2'd1: return a | b;
                2'd2: return a ^ b;
                default: return ~(a | b);
            endcase
        endcase
    endfunction

    function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b,
                                     logic [1:0] c, logic s);
        longint r;
        if (c != 2'd2) return 1'b0;
        r = s ? longint'($signed(a)) - longint'($signed(b))
              : longint'($signed(a)) + longint'($signed(b));
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(string req, logic [31:0] a, logic [31:0] b, logic [1:0] c,
                         logic s, logic [1:0] f, logic [2:0] sh);
        logic [31:0] e;
        @(negedge clk);
        op_a = a; op_b = b; fn_class = c; sub_en = s; bit_fn = f; shift_code = sh;
        #1;
        e = exp_res(a, b, c, s, f);
        chk(req, result, e);
        chk({req, " zero (R6)"}, {31'd0, zero}, {31'd0, e == 32'd0});
        chk({req, " overflow (R7)"}, {31'd0, overflow}, {31'd0, exp_ovf(a, b, c, s)});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r0, r1;
        logic [31:0] a, b;
        logic [1:0]  c;
        logic        s;
        void'($urandom(32'h5EED_1234));
        apply("R1 idle all-zero", 0, 0, 0, 0, 0, 0);
        apply("R2 upper imm", 32'hDEAD_BEEF, 32'hFFFF_1234, 0, 0, 0, 0);
        apply("R2 upper imm zero", 32'h1, 32'hABCD_0000, 0, 0, 0, 0);
        apply("R4 add", 32'd5, 32'd7, 2, 0, 0, 0);
        apply("R4 sub", 32'd5, 32'd7, 2, 1, 0, 0);
        apply("R4 sub equal", 32'h1234_5678, 32'h1234_5678, 2, 1, 0, 0);
        apply("R7 add max+1", 32'h7FFF_FFFF, 32'd1, 2, 0, 0, 0);
        apply("R7 sub min-1", 32'h8000_0000, 32'd1, 2, 1, 0, 0);
        apply("R7 add wrap no ovf", 32'hFFFF_FFFF, 32'd1, 2, 0, 0, 0);
        apply("R7 class3 no ovf", 32'h7FFF_FFFF, 32'd1, 3, 0, 1, 0);
        apply("R3 slt min<1", 32'h8000_0000, 32'd1, 1, 1, 0, 0);
        apply("R3 slt max vs -1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0);
        apply("R3 slt -1<max", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 1, 0, 0);
        apply("R3 slt equal", 32'd9, 32'd9, 1, 1, 0, 0);
        for (int f = 0; f < 4; f++)
            apply("R5 bitwise", 32'hF0F0_1234, 32'hFF00_8765, 3, 0, f[1:0], 0);
        apply("R5 nor all-ones zero", 32'h0, 32'hFFFF_FFFF, 3, 0, 3, 0);
        // R8: same vector under every shift code must give identical outputs
        for (int sh = 0; sh < 8; sh++)
            apply("R8 shift ignored", 32'h8000_0000, 32'h0000_0001, 2, 1, 0, sh[2:0]);
        @(negedge clk);
        op_a = 32'h1357_9BDF; op_b = 32'h2468_ACE0; fn_class = 2; sub_en = 0; shift_code = 0;
        #1 r0 = result;
        shift_code = 3'd7;
        #1 r1 = result;
        chk("R8 shift code change", r1, r0);
        for (int i = 0; i < 600; i++) begin
            a = $urandom; b = $urandom;
            c = 2'($urandom_range(0, 3));
            s = (c == 2'd1) ? 1'b1 : 1'($urandom_range(0, 1));
            if (i % 4 == 0) begin
                a[31] = 1'b1; b[31] = 1'b0;
                if (i % 8 == 0) begin a[31] = 1'b0; b[31] = 1'b1; end
            end
            apply("R1 random", a, b, c, s, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule